// File: doc/BRIEF.md
# Audio Block Enable Controller

This controller sequences the switch-on and switch-off of one audio sub-block. Software writes the run bit, the pin-drive bit and the DMA-permission bit through single-cycle write strobes. The serial frame engine supplies two signals: a level that is high while a frame is in progress, and a pulse on the last cycle of each frame. The controller then tells the engine whether it may start new frames. It also reports a run status that software can read, enables the audio output drivers, and gates the engine's DMA requests.

A switch-off request never cuts a frame short. If a frame is running, the controller enters a draining state. In that state the status still reads 1, but the engine is told to start no new frame. The status drops at the end of that frame. A request to switch on is accepted only while the status reads 0. A request that arrives while the status reads 1, including during draining, is discarded and leaves no trace.

The readable configuration word resets to 0x00000040. The run status is at bit 16, the DMA permission at bit 17 and the pin-drive bit at bit 13. All other bits hold their reset value.

Top module: `audio_enable_ctrl`

## Requirements
- R1: After reset, `cfg_rd` reads 0x00000040, and `run_status`, `eng_active`, `pin_drive_en` and `dma_req_out` are all 0.
- R2: A write of 1 to the run bit (`run_wr`=1, `run_wdata`=1) while `run_status` is 0 sets `run_status` and `eng_active` to 1 after the next clock edge.
- R3: A write of 1 to the run bit while the block is running (`run_status`=1, `eng_active`=1) changes no output.
- R4: A write of 0 to the run bit while `frame_busy`=1 and `frame_last`=0 drops `eng_active` after the next edge and keeps `run_status` at 1. `run_status` then falls after the edge on which `frame_last` is 1, and not before.
- R5: A write of 0 while `frame_busy`=0, or in the same cycle as `frame_last`=1, clears `run_status` and `eng_active` after the next edge.
- R6: While draining (`run_status`=1, `eng_active`=0), a write of 1 to the run bit is dropped. After the frame ends, the block stays off with no later effect.
- R7: With the pin-drive bit at 0, `pin_drive_en` equals `run_status`.
- R8: One edge after a write of 1 to the pin-drive bit (`drv_wr`=1, `drv_wdata`=1), `pin_drive_en` is 1 whatever the run state.
- R9: `dma_req_out` equals `dma_req_in` when the DMA-permission bit is 1, and is 0 when that bit is 0. The bit is loaded by `dma_wr`/`dma_wdata`.
- R10: In `cfg_rd`, bit 16 shows `run_status`, bit 17 the DMA-permission bit and bit 13 the pin-drive bit. All other bits stay at their reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_wr | input | 1 | Write strobe for the run bit |
| run_wdata | input | 1 | Value written to the run bit |
| drv_wr | input | 1 | Write strobe for the pin-drive bit |
| drv_wdata | input | 1 | Value written to the pin-drive bit |
| dma_wr | input | 1 | Write strobe for the DMA-permission bit |
| dma_wdata | input | 1 | Value written to the DMA-permission bit |
| frame_busy | input | 1 | High while the engine is inside a frame |
| frame_last | input | 1 | Pulse on the last cycle of a frame |
| dma_req_in | input | DMA_W | Raw DMA requests from the engine |
| run_status | output | 1 | Readable run status |
| eng_active | output | 1 | Engine may start new frames |
| pin_drive_en | output | 1 | Audio output driver enable |
| dma_req_out | output | DMA_W | Gated DMA requests |
| cfg_rd | output | 32 | Readable configuration word |

## Verification
The two functions that can fall in the same cycle are a software run-bit write and the engine's end-of-frame pulse. The bench provokes this in two ways. In the first, it raises `frame_last` in the very cycle a 0 is written while a frame is busy. The block is judged correct if it is off after that single edge, with no draining cycle. In the second, it writes 1 in the cycle of the pulse that ends a drain. The block is judged correct only if it stays off afterwards, because the write came while the status still read 1.

// File: rtl/audio_en_pkg.sv
package audio_en_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_DRAIN = 2'd2
  } run_state_e;
endpackage

// File: rtl/aen_rst_sync.sv
module aen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/aen_run_fsm.sv
module aen_run_fsm
  import audio_en_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_req,
  input  logic       clr_req,
  input  logic       frame_busy,
  input  logic       frame_last,
  output run_state_e state_q,
  output logic       status,
  output logic       active
);
  run_state_e state_d;
  logic       state_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (set_req) state_d = ST_ON;
      end
      ST_ON: begin
        if (clr_req) begin
          if (frame_busy && !frame_last) state_d = ST_DRAIN;
          else                           state_d = ST_OFF;
        end
      end
      ST_DRAIN: begin
        // any write here is dropped; only the frame end moves the state
        if (frame_last) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign state_en = (state_d != state_q);

  // state register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign status = (state_q != ST_OFF);
  assign active = (state_q == ST_ON);
endmodule

// File: rtl/aen_cfg_bits.sv
module aen_cfg_bits #(
  parameter int          DMA_W     = 1,
  parameter logic [31:0] CFG_RESET = 32'h0000_0040,
  parameter int          RUN_POS   = 16,
  parameter int          DMA_POS   = 17,
  parameter int          DRV_POS   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_wr,
  input  logic             drv_wdata,
  input  logic             dma_wr,
  input  logic             dma_wdata,
  input  logic             run_status,
  input  logic [DMA_W-1:0] dma_req_in,
  output logic             pin_drive_en,
  output logic [DMA_W-1:0] dma_req_out,
  output logic [31:0]      cfg_rd
);
  localparam logic [31:0] LIVE_MASK =
    (32'd1 << RUN_POS) | (32'd1 << DMA_POS) | (32'd1 << DRV_POS);
  localparam logic [31:0] FIXED_BITS = CFG_RESET & ~LIVE_MASK;

  logic drv_q, drv_d;
  logic dma_q, dma_d;

  always_comb begin
    drv_d = drv_q;
    dma_d = dma_q;
    if (drv_wr) drv_d = drv_wdata;
    if (dma_wr) dma_d = dma_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= CFG_RESET[DRV_POS];
    end else if (drv_wr) begin
      drv_q <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= CFG_RESET[DMA_POS];
    end else if (dma_wr) begin
      dma_q <= dma_d;
    end
  end

  assign pin_drive_en = drv_q | run_status;

  for (genvar g = 0; g < DMA_W; g++) begin : g_dma_gate
    assign dma_req_out[g] = dma_req_in[g] & dma_q;
  end

  always_comb begin
    cfg_rd          = FIXED_BITS;
    cfg_rd[RUN_POS] = run_status;
    cfg_rd[DMA_POS] = dma_q;
    cfg_rd[DRV_POS] = drv_q;
  end
endmodule

// File: rtl/audio_enable_ctrl.sv
module audio_enable_ctrl
  import audio_en_pkg::*;
#(
  parameter int          DMA_W       = 1,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] CFG_RESET   = 32'h0000_0040,
  parameter int          RUN_POS     = 16,
  parameter int          DMA_POS     = 17,
  parameter int          DRV_POS     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             drv_wr,
  input  logic             drv_wdata,
  input  logic             dma_wr,
  input  logic             dma_wdata,
  input  logic             frame_busy,
  input  logic             frame_last,
  input  logic [DMA_W-1:0] dma_req_in,
  output logic             run_status,
  output logic             eng_active,
  output logic             pin_drive_en,
  output logic [DMA_W-1:0] dma_req_out,
  output logic [31:0]      cfg_rd
);
  logic       rst_q_n;
  logic       set_req;
  logic       clr_req;
  run_state_e run_state;

  assign set_req = run_wr &  run_wdata;
  assign clr_req = run_wr & ~run_wdata;

  aen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  aen_run_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .set_req    (set_req),
    .clr_req    (clr_req),
    .frame_busy (frame_busy),
    .frame_last (frame_last),
    .state_q    (run_state),
    .status     (run_status),
    .active     (eng_active)
  );

  aen_cfg_bits #(
    .DMA_W     (DMA_W),
    .CFG_RESET (CFG_RESET),
    .RUN_POS   (RUN_POS),
    .DMA_POS   (DMA_POS),
    .DRV_POS   (DRV_POS)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .drv_wr       (drv_wr),
    .drv_wdata    (drv_wdata),
    .dma_wr       (dma_wr),
    .dma_wdata    (dma_wdata),
    .run_status   (run_status),
    .dma_req_in   (dma_req_in),
    .pin_drive_en (pin_drive_en),
    .dma_req_out  (dma_req_out),
    .cfg_rd       (cfg_rd)
  );
endmodule

// File: rtl/aen_checker.sv
module aen_checker #(
  parameter int DMA_W   = 1,
  parameter int DMA_POS = 17,
  parameter int DRV_POS = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_wr,
  input logic             run_wdata,
  input logic             frame_busy,
  input logic             frame_last,
  input logic             run_status,
  input logic             eng_active,
  input logic             pin_drive_en,
  input logic [DMA_W-1:0] dma_req_out,
  input logic [31:0]      cfg_rd
);
  // R2: accepted switch-on from the off state
  assert_enable_from_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_status && run_wr && run_wdata) |=> (run_status && eng_active));

  // R3: a set request while running changes nothing
  assert_set_ignored_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_active && run_wr && run_wdata) |=> (run_status && eng_active));

  // R4: draining holds the status until the frame ends
  assert_drain_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_status && !eng_active && !frame_last) |=> (run_status && !eng_active));

  // R4: status falls at the frame end
  assert_drain_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_status && !eng_active && frame_last) |=> !run_status);

  // R5: immediate switch-off with no frame pending
  assert_direct_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_active && run_wr && !run_wdata && (!frame_busy || frame_last)) |=> !run_status);

  // R6: a set request in the drain's last cycle is lost
  assert_drop_in_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_status && !eng_active && frame_last && run_wr && run_wdata) |=> (!run_status && !eng_active));

  // R7: drivers are on while running
  assert_drive_when_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_status |-> pin_drive_en);

  // R7: with the drive bit clear, drivers follow the status
  assert_drive_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[DRV_POS] |-> (pin_drive_en == run_status));

  // R9: no DMA request without permission
  assert_dma_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[DMA_POS] |-> (dma_req_out == '0));
endmodule

bind audio_enable_ctrl aen_checker #(
  .DMA_W   (DMA_W),
  .DMA_POS (DMA_POS),
  .DRV_POS (DRV_POS)
) u_aen_checker (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .run_wr       (run_wr),
  .run_wdata    (run_wdata),
  .frame_busy   (frame_busy),
  .frame_last   (frame_last),
  .run_status   (run_status),
  .eng_active   (eng_active),
  .pin_drive_en (pin_drive_en),
  .dma_req_out  (dma_req_out),
  .cfg_rd       (cfg_rd)
);

// File: tb/audio_enable_ctrl_test.sv
`timescale 1ns/1ps
module audio_enable_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        run_wr, run_wdata, drv_wr, drv_wdata, dma_wr, dma_wdata;
  logic        frame_busy, frame_last;
  logic [0:0]  dma_req_in, dma_req_out;
  logic        run_status, eng_active, pin_drive_en;
  logic [31:0] cfg_rd;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  audio_enable_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .run_wr(run_wr), .run_wdata(run_wdata),
    .drv_wr(drv_wr), .drv_wdata(drv_wdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .frame_busy(frame_busy), .frame_last(frame_last),
    .dma_req_in(dma_req_in),
    .run_status(run_status), .eng_active(eng_active),
    .pin_drive_en(pin_drive_en), .dma_req_out(dma_req_out),
    .cfg_rd(cfg_rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a strobe at a falling edge, clear it one cycle later
  task automatic write_run(input logic v);
    run_wr = 1'b1; run_wdata = v;
    step(1);
    run_wr = 1'b0; run_wdata = 1'b0;
  endtask

  task automatic write_drv(input logic v);
    drv_wr = 1'b1; drv_wdata = v;
    step(1);
    drv_wr = 1'b0; drv_wdata = 1'b0;
  endtask

  task automatic write_dma(input logic v);
    dma_wr = 1'b1; dma_wdata = v;
    step(1);
    dma_wr = 1'b0; dma_wdata = 1'b0;
  endtask

  task automatic pulse_last();
    frame_last = 1'b1;
    step(1);
    frame_last = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run_wr = 0; run_wdata = 0; drv_wr = 0; drv_wdata = 0;
    dma_wr = 0; dma_wdata = 0; frame_busy = 0; frame_last = 0;
    dma_req_in = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset_state();
    chk("R1 cfg_rd", cfg_rd, 32'h0000_0040);
    chk("R1 run_status", {31'd0, run_status}, 32'd0);
    chk("R1 eng_active", {31'd0, eng_active}, 32'd0);
    chk("R1 pin_drive_en", {31'd0, pin_drive_en}, 32'd0);
    dma_req_in = 1'b1;
    step(1);
    chk("R1 dma_req_out", {31'd0, dma_req_out}, 32'd0);
    dma_req_in = 1'b0;
  endtask

  task automatic t_enable();
    write_run(1'b1);
    chk("R2 run_status", {31'd0, run_status}, 32'd1);
    chk("R2 eng_active", {31'd0, eng_active}, 32'd1);
    chk("R10 cfg_rd run bit", cfg_rd, 32'h0001_0040);
  endtask

  task automatic t_set_while_on();
    write_run(1'b1);
    chk("R3 run_status", {31'd0, run_status}, 32'd1);
    chk("R3 eng_active", {31'd0, eng_active}, 32'd1);
  endtask

  task automatic t_disable_busy();
    frame_busy = 1'b1;
    write_run(1'b0);
    chk("R4 status held", {31'd0, run_status}, 32'd1);
    chk("R4 active dropped", {31'd0, eng_active}, 32'd0);
    step(3);
    chk("R4 status still held", {31'd0, run_status}, 32'd1);
    pulse_last();
    frame_busy = 1'b0;
    chk("R4 status cleared at frame end", {31'd0, run_status}, 32'd0);
    chk("R4 cfg_rd run bit", cfg_rd, 32'h0000_0040);
  endtask

  task automatic t_disable_idle();
    write_run(1'b1);
    frame_busy = 1'b0;
    write_run(1'b0);
    chk("R5 idle off", {31'd0, run_status}, 32'd0);
    chk("R5 idle inactive", {31'd0, eng_active}, 32'd0);
  endtask

  task automatic t_disable_same_cycle();
    write_run(1'b1);
    frame_busy = 1'b1;
    run_wr = 1'b1; run_wdata = 1'b0; frame_last = 1'b1;
    step(1);
    run_wr = 1'b0; frame_last = 1'b0; frame_busy = 1'b0;
    chk("R5 same-cycle frame end off", {31'd0, run_status}, 32'd0);
  endtask

  task automatic t_drop_in_drain();
    write_run(1'b1);
    frame_busy = 1'b1;
    write_run(1'b0);
    write_run(1'b1);
    chk("R6 still draining", {31'd0, run_status}, 32'd1);
    chk("R6 not reactivated", {31'd0, eng_active}, 32'd0);
    // write 1 in the same cycle as the ending pulse
    run_wr = 1'b1; run_wdata = 1'b1; frame_last = 1'b1;
    step(1);
    run_wr = 1'b0; run_wdata = 1'b0; frame_last = 1'b0; frame_busy = 1'b0;
    chk("R6 off after frame", {31'd0, run_status}, 32'd0);
    step(3);
    chk("R6 no later effect status", {31'd0, run_status}, 32'd0);
    chk("R6 no later effect active", {31'd0, eng_active}, 32'd0);
  endtask

  task automatic t_drive();
    chk("R7 drivers off when off", {31'd0, pin_drive_en}, 32'd0);
    write_run(1'b1);
    chk("R7 drivers on when running", {31'd0, pin_drive_en}, 32'd1);
    write_run(1'b0);
    chk("R7 drivers off again", {31'd0, pin_drive_en}, 32'd0);
    write_drv(1'b1);
    chk("R8 drivers on while off", {31'd0, pin_drive_en}, 32'd1);
    chk("R10 cfg_rd drive bit", cfg_rd, 32'h0000_2040);
    write_drv(1'b0);
    chk("R7 drive bit cleared", {31'd0, pin_drive_en}, 32'd0);
  endtask

  task automatic t_dma();
    dma_req_in = 1'b1;
    step(1);
    chk("R9 blocked without permission", {31'd0, dma_req_out}, 32'd0);
    write_dma(1'b1);
    chk("R9 passed with permission", {31'd0, dma_req_out}, 32'd1);
    chk("R10 cfg_rd dma bit", cfg_rd, 32'h0002_0040);
    dma_req_in = 1'b0;
    step(1);
    chk("R9 follows input low", {31'd0, dma_req_out}, 32'd0);
    write_dma(1'b0);
    dma_req_in = 1'b1;
    step(1);
    chk("R9 blocked again", {31'd0, dma_req_out}, 32'd0);
    dma_req_in = 1'b0;
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_enable();
    t_set_while_on();
    t_disable_busy();
    t_disable_idle();
    t_disable_same_cycle();
    t_drop_in_drain();
    t_drive();
    t_dma();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule